// File: doc/BRIEF.md
# Hall Commutation Gate Controller

This block turns three digitized rotor-position sensor levels into the six gate enables of a three-phase half-bridge inverter. Each valid sensor code picks one phase to source current (its high-side switch on) and one phase to sink it (its low-side switch on). The third phase floats with both of its gates off. A direction input reverses the rotation by swapping the source and sink phases. An active-low brake input shorts the windings through all low-side switches.

The enable input lets an external PWM signal chop the drive. A chop request from the on-chip current regulator does the same. During the off part of the chop, the source high side opens and the low side of the same phase closes, so the winding current decays slowly through the transistors instead of the body diodes. An overvoltage flag suppresses this synchronous rectification. The enable, direction and brake pins are synchronized and deglitched. Enable uses a shorter filter than the other two.

Every phase leg gets a dead-time interlock before any of its gates turns on. If enable stays high long enough, the block drops all gates and raises a standby flag. A fault flag overrides everything. All times are given in nanoseconds and converted to clock cycles from the clock frequency parameter.

Top module: `hall_commutator`

## Requirements
- R1: With fault low, brake_n high, enable low, chop low and dir_in high, a sensor code on hall_in, written {A,B,C}, drives one high-side gate and one low-side gate (source→sink) as follows: 100 A→B, 110 A→C, 010 B→C, 011 B→A, 001 C→A, 101 C→B. The gate bit order is bit0 = phase A, bit1 = B and bit2 = C, and every other gate stays off.
- R2: With dir_in low, the source and sink phases of R1 swap for every valid code.
- R3: The codes 000 and 111 turn all six gates off.
- R4: brake_n low turns all three low-side gates on and all high-side gates off. It does this whatever the enable, chop and sensor inputs are.
- R5: Enable high or chop_req high, with a valid code and no brake, turns the high-side gates off. The low sides of both the source phase and the sink phase are then on.
- R6: While ovp_in is high, the decay state of R5 keeps only the sink low side on. ovp_in has no effect while the bridge is driving.
- R7: Standby works as follows:
  - After enable has been high for STBY_NS (3 ms by default) with brake_n high, standby goes high and all gates turn off.
  - With brake_n low, standby never asserts.
  - Enable going low clears standby.
- R8: On enable, a pulse shorter than ENB_GLITCH_NS (500 ns) does not change the outputs. On dir_in and brake_n, a pulse shorter than PIN_GLITCH_NS (1000 ns) does not change them. A longer enable pulse does take effect.
- R9: A gate of a phase leg turns on only after both gates of that leg have been off for DEAD_NS (1 µs by default). When one gate of a leg hands over to the other, the second gate rises exactly DEAD_NS + one clock cycle after the first one falls. The two gates of a leg are never on together.
- R10: fault_in high turns all six gates off, and this overrides the brake.
- R11: While reset is applied and right after it, all gates and standby are low.
- R12: At most one high-side gate is on at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 3 | Sensor levels {A,B,C}, asynchronous |
| dir_in | input | 1 | 1 = forward, 0 = reverse, asynchronous |
| brake_n | input | 1 | Active-low brake, asynchronous |
| enb_in | input | 1 | Low = drive, high = chop/off, asynchronous |
| chop_req | input | 1 | Current regulator off-time request, synchronous |
| fault_in | input | 1 | Thermal, undervoltage or lock fault, synchronous |
| ovp_in | input | 1 | Supply overvoltage, synchronous |
| gate_hi | output | 3 | High-side gate enables, bit0 = A |
| gate_lo | output | 3 | Low-side gate enables, bit0 = A |
| standby | output | 1 | Standby entered on long enable-high |

## Verification
The checker assumes that fault_in, chop_req and ovp_in are synchronous to clk. The bench meets this by changing them only at falling edges. The fault and standby properties hold only once those conditions have persisted for two or three cycles, which covers the two register stages between the inputs and the gates. The bench holds each stimulus for tens of cycles, so the sensor, direction and brake inputs settle through their synchronizers and filters before the outputs are judged. Only the deglitch tests apply pulses deliberately shorter than the filter windows.

// File: rtl/hc_pkg.sv
package hc_pkg;

  typedef struct packed {
    logic       ok;
    logic [1:0] src;
    logic [1:0] snk;
  } step_t;

  function automatic int ns_to_cycles(int clk_hz, int ns);
    longint prod;
    prod = longint'(clk_hz) * longint'(ns);
    return int'(prod / 64'sd1_000_000_000);
  endfunction

  function automatic logic [2:0] phase_bit(logic [1:0] p);
    return 3'b001 << p;
  endfunction

  // Code {A,B,C} to source/sink phase (0=A,1=B,2=C); reverse swaps them.
  function automatic step_t hall_step(logic [2:0] code, logic fwd);
    step_t s;
    s = '{ok: 1'b1, src: 2'd0, snk: 2'd0};
    case (code)
      3'b100: begin s.src = 2'd0; s.snk = 2'd1; end
      3'b110: begin s.src = 2'd0; s.snk = 2'd2; end
      3'b010: begin s.src = 2'd1; s.snk = 2'd2; end
      3'b011: begin s.src = 2'd1; s.snk = 2'd0; end
      3'b001: begin s.src = 2'd2; s.snk = 2'd0; end
      3'b101: begin s.src = 2'd2; s.snk = 2'd1; end
      default: s.ok = 1'b0;
    endcase
    if (!fwd) begin
      s.src = s.snk;
      s.snk = (code == 3'b100) ? 2'd0 :
              (code == 3'b110) ? 2'd0 :
              (code == 3'b010) ? 2'd1 :
              (code == 3'b011) ? 2'd1 : 2'd2;
    end
    return s;
  endfunction

endpackage

// File: rtl/hc_sync2.sv
module hc_sync2 #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hc_glitch_filter.sv
module hc_glitch_filter #(
  parameter int   LEN     = 5,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int LIM = (LEN < 1) ? 1 : LEN;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= RST_VAL;
      run <= '0;
    end else if (d != q) begin
      if (run == CW'(LIM - 1)) begin
        q   <= d;
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end else begin
      run <= '0;
    end
  end
endmodule

// File: rtl/hc_gate_select.sv
module hc_gate_select
  import hc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] hall,
  input  logic       fwd,
  input  logic       brk_n,
  input  logic       enb,
  input  logic       chop,
  input  logic       ovp,
  input  logic       fault,
  input  logic       stby,
  output logic [2:0] req_hi,
  output logic [2:0] req_lo
);
  step_t      st;
  logic [2:0] hi_n;
  logic [2:0] lo_n;

  always_comb begin
    st   = hall_step(hall, fwd);
    hi_n = '0;
    lo_n = '0;
    if (fault || stby) begin
      hi_n = '0;
      lo_n = '0;
    end else if (!brk_n) begin
      lo_n = 3'b111;
    end else if (st.ok) begin
      if (!enb && !chop) begin
        hi_n = phase_bit(st.src);
        lo_n = phase_bit(st.snk);
      end else begin
        lo_n = phase_bit(st.snk) | (ovp ? 3'b000 : phase_bit(st.src));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_hi <= '0;
      req_lo <= '0;
    end else begin
      req_hi <= hi_n;
      req_lo <= lo_n;
    end
  end
endmodule

// File: rtl/hc_dead_leg.sv
module hc_dead_leg #(
  parameter int DT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic want_hi,
  input  logic want_lo,
  output logic hi_o,
  output logic lo_o
);
  localparam int CW = (DT < 1) ? 1 : $clog2(DT + 1);

  logic [CW-1:0] idle;
  logic          gap_ok;

  assign gap_ok = (idle == CW'(DT));

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_o <= 1'b0;
      lo_o <= 1'b0;
      idle <= '0;
    end else begin
      hi_o <= want_hi && !want_lo && (hi_o || (!lo_o && gap_ok));
      lo_o <= want_lo && !want_hi && (lo_o || (!hi_o && gap_ok));
      if (hi_o || lo_o)
        idle <= '0;
      else if (!gap_ok)
        idle <= idle + 1'b1;
    end
  end
endmodule

// File: rtl/hc_standby_timer.sv
module hc_standby_timer #(
  parameter int LIMIT = 30000
) (
  input  logic clk,
  input  logic rst,
  input  logic enb,
  input  logic brk_n,
  output logic stby
);
  localparam int LIM = (LIMIT < 1) ? 1 : LIMIT;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      stby <= 1'b0;
    end else if (!enb || !brk_n) begin
      held <= '0;
      stby <= 1'b0;
    end else if (held == CW'(LIM)) begin
      stby <= 1'b1;
    end else begin
      held <= held + 1'b1;
    end
  end
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hc_pkg::*;
#(
  parameter int CLK_HZ        = 10_000_000,
  parameter int ENB_GLITCH_NS = 500,
  parameter int PIN_GLITCH_NS = 1000,
  parameter int DEAD_NS       = 1000,
  parameter int STBY_NS       = 3_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] hall_in,
  input  logic       dir_in,
  input  logic       brake_n,
  input  logic       enb_in,
  input  logic       chop_req,
  input  logic       fault_in,
  input  logic       ovp_in,
  output logic [2:0] gate_hi,
  output logic [2:0] gate_lo,
  output logic       standby
);
  localparam int ENB_LEN  = ns_to_cycles(CLK_HZ, ENB_GLITCH_NS);
  localparam int PIN_LEN  = ns_to_cycles(CLK_HZ, PIN_GLITCH_NS);
  localparam int DEAD_CYC = ns_to_cycles(CLK_HZ, DEAD_NS);
  localparam int STBY_CYC = ns_to_cycles(CLK_HZ, STBY_NS);
  localparam int NPIN     = 3;

  logic [2:0]      hall_s;
  logic [NPIN-1:0] pin_s;
  logic [NPIN-1:0] pin_f;
  logic [2:0]      req_hi;
  logic [2:0]      req_lo;

  hc_sync2 #(.W(3), .RST_VAL(3'b000)) i_hall_sync (
    .clk(clk), .rst(rst), .d(hall_in), .q(hall_s)
  );

  // pin order: 0 = enable, 1 = brake_n, 2 = direction
  hc_sync2 #(.W(NPIN), .RST_VAL(3'b111)) i_pin_sync (
    .clk(clk), .rst(rst), .d({dir_in, brake_n, enb_in}), .q(pin_s)
  );

  for (genvar g = 0; g < NPIN; g++) begin : g_filt
    localparam int FLEN = (g == 0) ? ENB_LEN : PIN_LEN;
    hc_glitch_filter #(.LEN(FLEN), .RST_VAL(1'b1)) i_filt (
      .clk(clk), .rst(rst), .d(pin_s[g]), .q(pin_f[g])
    );
  end

  hc_standby_timer #(.LIMIT(STBY_CYC)) i_stby (
    .clk(clk), .rst(rst), .enb(pin_f[0]), .brk_n(pin_f[1]), .stby(standby)
  );

  hc_gate_select i_sel (
    .clk(clk), .rst(rst), .hall(hall_s), .fwd(pin_f[2]), .brk_n(pin_f[1]),
    .enb(pin_f[0]), .chop(chop_req), .ovp(ovp_in), .fault(fault_in),
    .stby(standby), .req_hi(req_hi), .req_lo(req_lo)
  );

  for (genvar p = 0; p < 3; p++) begin : g_leg
    hc_dead_leg #(.DT(DEAD_CYC)) i_leg (
      .clk(clk), .rst(rst), .want_hi(req_hi[p]), .want_lo(req_lo[p]),
      .hi_o(gate_hi[p]), .lo_o(gate_lo[p])
    );
  end
endmodule

// File: rtl/hc_checker.sv
module hc_checker
  import hc_pkg::*;
#(
  parameter int CLK_HZ  = 10_000_000,
  parameter int DEAD_NS = 1000
) (
  input logic       clk,
  input logic       rst,
  input logic       fault_in,
  input logic       standby,
  input logic [2:0] gate_hi,
  input logic [2:0] gate_lo
);
  localparam int DT = ns_to_cycles(CLK_HZ, DEAD_NS);
  localparam int CW = $clog2(DT + 2);

  assert_no_shoot_through_R9: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == 3'b000);

  assert_one_source_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gate_hi));

  assert_fault_off_R10: assert property (@(posedge clk) disable iff (rst)
    (fault_in && $past(fault_in)) |=> (gate_hi == 3'b000 && gate_lo == 3'b000));

  assert_standby_off_R7: assert property (@(posedge clk) disable iff (rst)
    (standby && $past(standby) && $past(standby, 2))
      |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

  for (genvar p = 0; p < 3; p++) begin : g_dt
    logic [CW-1:0] off_run;
    always_ff @(posedge clk) begin
      if (rst)
        off_run <= '0;
      else if (gate_hi[p] || gate_lo[p])
        off_run <= '0;
      else if (off_run < CW'(DT + 1))
        off_run <= off_run + 1'b1;
    end

    assert_dead_time_R9: assert property (@(posedge clk) disable iff (rst)
      ($rose(gate_hi[p] | gate_lo[p])) |-> (off_run >= CW'(DT)));
  end
endmodule

bind hall_commutator hc_checker #(.CLK_HZ(CLK_HZ), .DEAD_NS(DEAD_NS)) i_hc_checker (
  .clk(clk), .rst(rst), .fault_in(fault_in), .standby(standby),
  .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/test_hall_commutator.sv
module test_hall_commutator;
  localparam int DT      = 10;     // 1000 ns at 10 MHz cycle accounting
  localparam int SETTLE  = 80;
  localparam int NVEC    = 18;
  localparam int MAXCYC  = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] hall_in = 3'b100;
  logic       dir_in = 1'b1, brake_n = 1'b1, enb_in = 1'b1;
  logic       chop_req = 1'b0, fault_in = 1'b0, ovp_in = 1'b0;
  logic [2:0] gate_hi, gate_lo;
  logic       standby;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hall_commutator i_hall_commutator (
    .clk(clk), .rst(rst), .hall_in(hall_in), .dir_in(dir_in), .brake_n(brake_n),
    .enb_in(enb_in), .chop_req(chop_req), .fault_in(fault_in), .ovp_in(ovp_in),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .standby(standby)
  );

  // fields: hall, dir, enb, chop, ovp, brake_n, exp_hi, exp_lo
  localparam logic [13:0] VECS [NVEC] = '{
    {3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001, 3'b010},
    {3'b110, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001, 3'b100},
    {3'b010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'b010, 3'b100},
    {3'b011, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'b010, 3'b001},
    {3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'b100, 3'b001},
    {3'b101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'b100, 3'b010},
    {3'b100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b010, 3'b001},
    {3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b001, 3'b100},
    {3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b100, 3'b010},
    {3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000},
    {3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000},
    {3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b000, 3'b011},
    {3'b100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'b000, 3'b011},
    {3'b110, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'b000, 3'b100},
    {3'b011, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'b010, 3'b001},
    {3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b111},
    {3'b100, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 3'b111},
    {3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b111}
  };

  function automatic string vec_req(int i);
    if (i < 6)  return "R1";
    if (i < 9)  return "R2";
    if (i < 11) return "R3";
    if (i < 13) return "R5";
    if (i < 15) return "R6";
    return "R4";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_steady();
    hall_in = 3'b100; dir_in = 1'b1; enb_in = 1'b0; chop_req = 1'b0;
    ovp_in = 1'b0; brake_n = 1'b1; fault_in = 1'b0;
    wait_cyc(SETTLE);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (MAXCYC) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin
    int fall_at, rise_at;
    bit stable;
    logic [13:0] v;

    // R11 reset state
    wait_cyc(5);
    check("R11 gates in reset", {gate_hi, gate_lo, standby}, 0);
    rst = 1'b0;
    wait_cyc(1);
    check("R11 gates after reset", {gate_hi, gate_lo, standby}, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      hall_in  = v[13:11];
      dir_in   = v[10];
      enb_in   = v[9];
      chop_req = v[8];
      ovp_in   = v[7];
      brake_n  = v[6];
      wait_cyc(SETTLE);
      check({vec_req(i), " high gates"}, gate_hi, v[5:3]);
      check({vec_req(i), " low gates"},  gate_lo, v[2:0]);
      check("R12 one source", int'($countones(gate_hi) <= 1), 1);
    end

    // R9 dead time on chop hand-over, leg A high -> leg A low
    drive_steady();
    chop_req = 1'b1;
    fall_at = -1; rise_at = -1; stable = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (gate_hi[0] && gate_lo[0]) stable = 1'b0;
      if (fall_at < 0 && !gate_hi[0]) fall_at = c;
      if (rise_at < 0 && gate_lo[0]) rise_at = c;
    end
    check("R9 dead-time gap", rise_at - fall_at, DT + 1);
    check("R9 no overlap", stable, 1);
    chop_req = 1'b0;

    // R8 short enable pulse ignored
    drive_steady();
    stable = 1'b1;
    enb_in = 1'b1; wait_cyc(3); enb_in = 1'b0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (gate_hi != 3'b001 || gate_lo != 3'b010) stable = 1'b0;
    end
    check("R8 short enable pulse", stable, 1);

    // R8 longer enable pulse takes effect
    stable = 1'b1;
    enb_in = 1'b1; wait_cyc(8); enb_in = 1'b0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (gate_hi != 3'b001) stable = 1'b0;
    end
    check("R8 long enable pulse seen", stable, 0);

    // R8 short direction pulse ignored
    drive_steady();
    stable = 1'b1;
    dir_in = 1'b0; wait_cyc(8); dir_in = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (gate_hi != 3'b001 || gate_lo != 3'b010) stable = 1'b0;
    end
    check("R8 short direction pulse", stable, 1);

    // R8 short brake pulse ignored
    stable = 1'b1;
    brake_n = 1'b0; wait_cyc(8); brake_n = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (gate_hi != 3'b001 || gate_lo != 3'b010) stable = 1'b0;
    end
    check("R8 short brake pulse", stable, 1);

    // R10 fault overrides brake
    brake_n = 1'b0;
    wait_cyc(SETTLE);
    check("R4 brake before fault", gate_lo, 3'b111);
    fault_in = 1'b1;
    wait_cyc(5);
    check("R10 fault over brake", {gate_hi, gate_lo}, 0);
    fault_in = 1'b0;
    wait_cyc(SETTLE);
    check("R10 brake after fault", gate_lo, 3'b111);

    // R7 brake blocks standby
    enb_in = 1'b1;
    wait_cyc(31000);
    check("R7 brake blocks standby", standby, 0);
    check("R7 brake still active", gate_lo, 3'b111);

    // R7 standby entry and exit
    brake_n = 1'b1;
    wait_cyc(29000);
    check("R7 standby not yet", standby, 0);
    wait_cyc(2000);
    check("R7 standby asserted", standby, 1);
    check("R7 standby gates off", {gate_hi, gate_lo}, 0);
    enb_in = 1'b0;
    wait_cyc(20);
    check("R7 standby cleared", standby, 0);
    wait_cyc(SETTLE);
    check("R7 drive resumes high", gate_hi, 3'b001);
    check("R7 drive resumes low", gate_lo, 3'b010);

    finish_run();
  end
endmodule